// File: doc/BRIEF.md
# Four-Slot Descriptor Ring Queue

This block holds up to four transfer descriptors for one DMA channel. A host loads each descriptor by writing four 32-bit words to a single push address. The words arrive in a fixed order: address low, address high, byte length, flags. A DMA engine on the consumer side takes whole descriptors through a valid/ready handshake. Each descriptor it receives carries a 64-bit address, a 32-bit length, a 32-bit flags word and a decoded completion-notify bit.

The host sees the queue through a small register window of three registers.
- Control: bit 0 holds the ring in reset.
- Status: shows the two slot pointers, the empty, full and error flags, and clears the error flag on a write of 1 to bit 10.
- Push: takes the descriptor words.

When the two pointers are equal, the separate full and empty flags tell a full ring from an empty one. A descriptor that is completed while the ring is full is discarded, and the error flag is raised.

Top module: `desc_ring_queue`

## Requirements
- R1: After reset the status register reads 0x100 (empty), the control register reads 0, and `pop_valid` is low.
- R2: Writes to the push offset (0x8) collect words in the order address low, address high, length, flags. Only the fourth word commits a descriptor. The popped descriptor carries address = {word 1, word 0}, length = word 2 and flags = word 3.
- R3: Reads of the status offset (0x4) return the write slot index in bits [1:0], the read slot index in bits [5:4], empty in bit 8, full in bit 9 and error in bit 10. All other bits are zero. Reads of the control offset (0x0) return the reset bit in bit 0. Reads of any other offset return 0.
- R4: The ring holds exactly four descriptors. With four held, the pointers are equal and only full is set. With none held, only empty is set. Otherwise occupancy is (write − read) mod 4.
- R5: A fourth word that arrives while the ring is full is dropped. The ring contents and the pointers are left unchanged, and the error flag is set.
- R6: Writing the status offset with bit 10 set clears the error flag. No other bit of a status write has any effect.
- R7: While control bit 0 reads 1, and on the cycle of the write that sets it, both pointers and the full flag are cleared and any partial word count is discarded.
  - Push writes made during that time are ignored.
  - The error flag is not changed.
  - Writing 0 releases the reset.
- R8: A descriptor leaves when `pop_valid` and `pop_ready` are both high. The read slot then advances by one. Descriptors leave in the order they were committed. `pop_ready` while the ring is empty has no effect.
- R9: `pop_notify` equals bit 16 of the flags word of the head descriptor.
- R10: When a fourth word arrives on the same cycle as a pop from a full ring, the word is still dropped as an overflow and the pop still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W (4) | Register offset for writes and reads |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| pop_valid | output | 1 | Head descriptor is available |
| pop_ready | input | 1 | Consumer takes the head descriptor |
| pop_addr | output | 64 | Head descriptor address |
| pop_len | output | 32 | Head descriptor byte length |
| pop_flags | output | 32 | Head descriptor flags word |
| pop_notify | output | 1 | Completion notification requested by the head descriptor |

## Verification
The hardest case to reach is a full ring whose fourth descriptor word lands on the same cycle as a consumer pop. Both the overflow rule and the pointer update act at once in that case. The stimulus first fills the ring with `pop_ready` held low and writes three words of a fifth descriptor. It then raises `pop_ready` on the cycle of the fourth word. A second hard case is a ring reset that arrives in the middle of a descriptor while the error flag is set. The stimulus leaves a two-word partial descriptor pending before asserting the control bit. It then checks that the next descriptor after release needs four full words and that the error flag stays set. A long stretch of random word writes, pops and rare register writes is then compared against the queue-based model on every cycle.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int SLOT_COUNT = 4;
    localparam int PTR_W      = $clog2(SLOT_COUNT);
    localparam int WORD_COUNT = 4;
    localparam int WC_W       = $clog2(WORD_COUNT);

    localparam int ST_WR_LSB  = 0;
    localparam int ST_RD_LSB  = 4;
    localparam int ST_EMPTY   = 8;
    localparam int ST_FULL    = 9;
    localparam int ST_ERR     = 10;
    localparam int CTRL_CLR   = 0;
    localparam int NOTIFY_BIT = 16;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] len;
        logic [31:0] flags;
    } desc_t;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic             full;
    } ring_ptr_t;

    typedef struct packed {
        logic [WC_W-1:0] wc;
        logic [31:0]     w0;
        logic [31:0]     w1;
        logic [31:0]     w2;
    } asm_st_t;

    typedef struct packed {
        logic ctrl;
        logic err;
    } csr_st_t;
endpackage

// File: rtl/dq_assembler.sv
module dq_assembler
    import dq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        word_we,
    input  logic [31:0] word_data,
    output logic        push,
    output desc_t       push_desc
);
    asm_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        push = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (word_we) begin
            case (st_q.wc)
                WC_W'(0): st_d.w0 = word_data;
                WC_W'(1): st_d.w1 = word_data;
                WC_W'(2): st_d.w2 = word_data;
                default:  push = 1'b1;
            endcase
            st_d.wc = st_q.wc + WC_W'(1);
        end
        push_desc.addr  = {st_q.w1, st_q.w0};
        push_desc.len   = st_q.w2;
        push_desc.flags = word_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: each accepted word moves the counter by exactly one
    p_word_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_we && !clear) |=> (st_q.wc == $past(st_q.wc) + WC_W'(1)));

    // R7: a ring reset discards any partial descriptor
    p_count_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.wc == '0));
endmodule

// File: rtl/dq_ring.sv
module dq_ring
    import dq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  desc_t            push_desc,
    input  logic             pop_ready,
    output logic             pop_valid,
    output desc_t            pop_desc,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             full,
    output logic             empty,
    output logic             overflow
);
    ring_ptr_t ptr_q, ptr_d;
    logic      accept;
    logic      fire;
    desc_t     slot_view [SLOT_COUNT];

    assign empty     = (ptr_q.wr == ptr_q.rd) && !ptr_q.full;
    assign pop_valid = !empty;
    assign fire      = pop_valid && pop_ready;
    assign accept    = push && !ptr_q.full;
    assign overflow  = push && ptr_q.full;

    always_comb begin
        ptr_d = ptr_q;
        if (clear) begin
            ptr_d = '0;
        end else begin
            if (accept) ptr_d.wr = ptr_q.wr + PTR_W'(1);
            if (fire)   ptr_d.rd = ptr_q.rd + PTR_W'(1);
            if (accept && !fire && (PTR_W'(ptr_q.wr + PTR_W'(1)) == ptr_q.rd))
                ptr_d.full = 1'b1;
            else if (fire && !accept)
                ptr_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_slot
        desc_t slot_q, slot_d;
        always_comb begin
            slot_d = slot_q;
            if (accept && !clear && ptr_q.wr == PTR_W'(g)) slot_d = push_desc;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end
        assign slot_view[g] = slot_q;
    end

    assign pop_desc = slot_view[ptr_q.rd];
    assign wr_ptr   = ptr_q.wr;
    assign rd_ptr   = ptr_q.rd;
    assign full     = ptr_q.full;

    // R4: a full ring always has coinciding pointers
    p_full_ptrs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (wr_ptr == rd_ptr));

    // R5: an overflowing push leaves the write pointer and full flag alone
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !fire && !clear) |=> (full && wr_ptr == $past(wr_ptr)));

    // R8: every pop advances the read slot by one
    p_pop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clear) |=> (rd_ptr == $past(rd_ptr) + PTR_W'(1)));

    // R7: ring reset zeroes both pointers and the full flag
    p_ring_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (wr_ptr == '0 && rd_ptr == '0 && !full));
endmodule

// File: rtl/dq_csr.sv
module dq_csr
    import dq_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h4,
    parameter logic [ADDR_W-1:0] DESC_OFS = 'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              wbit_clr,
    input  logic              wbit_err,
    output logic [31:0]       host_rdata,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic              full,
    input  logic              empty,
    input  logic              overflow,
    output logic              clear,
    output logic              desc_we
);
    csr_st_t st_q, st_d;
    logic    sel_ctrl, sel_stat, sel_desc;
    logic    err_clr;
    logic [31:0] status_word;

    assign sel_ctrl = (host_addr == CTRL_OFS);
    assign sel_stat = (host_addr == STAT_OFS);
    assign sel_desc = (host_addr == DESC_OFS);
    assign err_clr  = host_wr && sel_stat && wbit_err;
    assign clear    = st_q.ctrl || (host_wr && sel_ctrl && wbit_clr);
    assign desc_we  = host_wr && sel_desc;

    always_comb begin
        st_d = st_q;
        if (host_wr && sel_ctrl) st_d.ctrl = wbit_clr;
        if (overflow)            st_d.err  = 1'b1;
        else if (err_clr)        st_d.err  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_word = '0;
        status_word[ST_WR_LSB +: PTR_W] = wr_ptr;
        status_word[ST_RD_LSB +: PTR_W] = rd_ptr;
        status_word[ST_EMPTY]           = empty;
        status_word[ST_FULL]            = full;
        status_word[ST_ERR]             = st_q.err;
        host_rdata = '0;
        if (sel_stat)      host_rdata = status_word;
        else if (sel_ctrl) host_rdata[CTRL_CLR] = st_q.ctrl;
    end

    // R5: an overflow always leaves the error flag raised
    p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> st_q.err);

    // R6: only a status write with the clear bit drops the error flag
    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !err_clr) |=> st_q.err);

    // R4: full and empty are never reported together
    p_flag_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/desc_ring_queue.sv
module desc_ring_queue
    import dq_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h4,
    parameter logic [ADDR_W-1:0] DESC_OFS = 'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [63:0]       pop_addr,
    output logic [31:0]       pop_len,
    output logic [31:0]       pop_flags,
    output logic              pop_notify
);
    logic             clear, desc_we, push, overflow, full, empty;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    desc_t            push_desc, head;

    dq_csr #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .STAT_OFS(STAT_OFS),
        .DESC_OFS(DESC_OFS)
    ) i_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .wbit_clr  (host_wdata[CTRL_CLR]),
        .wbit_err  (host_wdata[ST_ERR]),
        .host_rdata(host_rdata),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .full      (full),
        .empty     (empty),
        .overflow  (overflow),
        .clear     (clear),
        .desc_we   (desc_we)
    );

    dq_assembler i_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .word_we  (desc_we),
        .word_data(host_wdata),
        .push     (push),
        .push_desc(push_desc)
    );

    dq_ring i_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .push     (push),
        .push_desc(push_desc),
        .pop_ready(pop_ready),
        .pop_valid(pop_valid),
        .pop_desc (head),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .full     (full),
        .empty    (empty),
        .overflow (overflow)
    );

    assign pop_addr   = head.addr;
    assign pop_len    = head.len;
    assign pop_flags  = head.flags;
    assign pop_notify = head.flags[NOTIFY_BIT];
endmodule

// File: tb/test_desc_ring_queue.sv
module test_desc_ring_queue;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_DESC = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = A_STAT;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        pop_valid, pop_ready = 1'b0, pop_notify;
    logic [63:0] pop_addr;
    logic [31:0] pop_len, pop_flags;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference state
    logic [127:0] mq[$];
    int           m_rd = 0;
    int           m_wc = 0;
    logic [31:0]  m_w[3];
    bit           m_err = 0;
    bit           m_ctrl = 0;

    always #5 clk = ~clk;

    desc_ring_queue i_desc_ring_queue (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .pop_valid(pop_valid),
        .pop_ready(pop_ready), .pop_addr(pop_addr), .pop_len(pop_len),
        .pop_flags(pop_flags), .pop_notify(pop_notify)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        logic [31:0] s = '0;
        int sz = mq.size();
        s[1:0]  = 2'((m_rd + sz) % 4);
        s[5:4]  = 2'(m_rd);
        s[8]    = (sz == 0);
        s[9]    = (sz == 4);
        s[10]   = m_err;
        return s;
    endfunction

    task automatic model_step();
        bit clr  = m_ctrl || (host_wr && host_addr == A_CTRL && host_wdata[0]);
        bit fire = pop_ready && (mq.size() > 0);
        bit do_push = 0;
        if (clr) begin
            mq.delete();
            m_rd = 0;
            m_wc = 0;
        end else begin
            if (host_wr && host_addr == A_DESC) begin
                if (m_wc == 3) begin
                    if (mq.size() == 4) m_err = 1;
                    else do_push = 1;
                end else begin
                    m_w[m_wc] = host_wdata;
                end
                m_wc = (m_wc + 1) % 4;
            end
            if (fire) begin
                void'(mq.pop_front());
                m_rd = (m_rd + 1) % 4;
            end
            if (do_push) mq.push_back({m_w[1], m_w[0], m_w[2], host_wdata});
        end
        if (host_wr && host_addr == A_STAT && host_wdata[10]) m_err = 0;
        if (host_wr && host_addr == A_CTRL) m_ctrl = host_wdata[0];
    endtask

    task automatic compare();
        logic [31:0] exp_rd;
        exp_rd = (host_addr == A_STAT) ? m_status() :
                 (host_addr == A_CTRL) ? {31'b0, m_ctrl} : 32'h0;
        chk("R3 rdata", 128'(host_rdata), 128'(exp_rd));
        chk("R8 pop_valid", 128'(pop_valid), 128'(mq.size() > 0));
        if (mq.size() > 0) begin
            chk("R2 descriptor", {pop_addr, pop_len, pop_flags}, mq[0]);
            chk("R9 notify", 128'(pop_notify), 128'(mq[0][16]));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic bus(logic [3:0] a, logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        tick();
        host_wr = 1'b0; host_addr = A_STAT; host_wdata = '0;
        #1;
    endtask

    task automatic push4(logic [31:0] lo, logic [31:0] hi, logic [31:0] len, logic [31:0] fl);
        bus(A_DESC, lo); bus(A_DESC, hi); bus(A_DESC, len); bus(A_DESC, fl);
    endtask

    task automatic read_ctrl(string tag, logic [31:0] exp);
        host_addr = A_CTRL; #1;
        chk(tag, 128'(host_rdata), 128'(exp));
        host_addr = A_STAT; #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", 128'(host_rdata), 128'(32'h100));
        chk("R1 pop_valid", 128'(pop_valid), 128'(0));
        read_ctrl("R1 ctrl", 32'h0);

        // R2 R9: one descriptor with notify
        push4(32'h1000, 32'h2, 32'h40, 32'h0001_0000);
        chk("R3 status one", 128'(host_rdata), 128'(32'h001));
        chk("R2 addr", 128'(pop_addr), 128'(64'h2_0000_1000));
        chk("R2 len", 128'(pop_len), 128'(32'h40));
        chk("R9 notify set", 128'(pop_notify), 128'(1));

        // R8: pop it
        pop_ready = 1'b1; tick(); pop_ready = 1'b0;
        chk("R8 after pop", 128'(host_rdata), 128'(32'h111));

        // R4: fill the ring
        for (int i = 0; i < 4; i++) push4(32'h100 * i, 32'h0, 32'h10 + i, 32'(i));
        chk("R4 full", 128'(host_rdata), 128'(32'h211));
        chk("R9 notify clear", 128'(pop_notify), 128'(0));

        // R5: overflow
        push4(32'hDEAD, 32'hBEEF, 32'h99, 32'h1_0000);
        chk("R5 overflow", 128'(host_rdata), 128'(32'h611));
        chk("R5 head kept", 128'(pop_len), 128'(32'h10));

        // R6: status writes
        bus(A_STAT, 32'h3FF);
        chk("R6 no clear", 128'(host_rdata), 128'(32'h611));
        bus(A_STAT, 32'h400);
        chk("R6 clear", 128'(host_rdata), 128'(32'h211));

        // R10: fourth word together with a pop while full
        bus(A_DESC, 32'h1); bus(A_DESC, 32'h2); bus(A_DESC, 32'h3);
        pop_ready = 1'b1;
        bus(A_DESC, 32'h4);
        pop_ready = 1'b0;
        chk("R10 push dropped pop done", 128'(host_rdata), 128'(32'h421));

        // R7: ring reset mid-descriptor, error kept
        bus(A_DESC, 32'hAA); bus(A_DESC, 32'hBB);
        bus(A_CTRL, 32'h1);
        chk("R7 cleared", 128'(host_rdata), 128'(32'h500));
        read_ctrl("R7 ctrl readback", 32'h1);
        push4(32'h5, 32'h6, 32'h7, 32'h8);
        chk("R7 writes ignored", 128'(host_rdata), 128'(32'h500));
        chk("R7 no valid", 128'(pop_valid), 128'(0));
        bus(A_CTRL, 32'h0);
        read_ctrl("R7 released", 32'h0);
        bus(A_STAT, 32'h400);
        push4(32'h11, 32'h22, 32'h33, 32'h44);
        chk("R7 fresh count", 128'(host_rdata), 128'(32'h001));
        chk("R7 fresh addr", 128'(pop_addr), 128'(64'h22_0000_0011));

        // R8: pop, then pop_ready on empty ring
        pop_ready = 1'b1;
        repeat (4) tick();
        pop_ready = 1'b0;
        chk("R8 empty pops ignored", 128'(host_rdata), 128'(32'h111));

        // random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            int r = $urandom_range(0, 31);
            pop_ready = ($urandom_range(0, 2) == 0);
            host_wr = 1'b0; host_addr = A_STAT; host_wdata = $urandom;
            if (r < 14) begin
                host_wr = 1'b1; host_addr = A_DESC;
            end else if (r == 14) begin
                host_wr = 1'b1; host_addr = A_STAT;
            end else if (r == 15 && $urandom_range(0, 7) == 0) begin
                host_wr = 1'b1; host_addr = A_CTRL;
                host_wdata = 32'(!m_ctrl);
            end else if (r == 16 && m_ctrl) begin
                host_wr = 1'b1; host_addr = A_CTRL; host_wdata = 32'h0;
            end else if (r == 17) begin
                host_addr = A_CTRL;
            end
            tick();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule